// File: doc/BRIEF.md
# Interrupt Destination Resolver with Rotating Lowest-Priority Pick

This block takes the addressing fields of one interrupt message and turns them into a mask of the processor interrupt units that must receive it. There are up to eight units. A message arrives on a single-cycle strobe. It carries a destination byte, a bit that picks physical or logical addressing, and a delivery code. Every unit also presents its own logical-destination byte. One clock later the block presents the target mask, a result strobe, and an error flag for an addressing combination that is not allowed.

In physical addressing the destination byte is a unit number. The all-ones value reaches every unit. In logical addressing a unit takes part when its logical byte shares at least one set bit with the destination byte.

For lowest-priority delivery the block does not compare unit priorities. It keeps a persistent rotation counter. From the matched units, taken in ascending unit order, it keeps only the member whose rank equals the counter modulo the number of matches. The counter then steps by one, so repeated messages are spread across the eligible units.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical mode (`msg_logical`=0) with a delivery code other than lowest-priority, destination 0xFF sets every bit of `tgt_mask`.
- R2: In physical mode with a non-lowest-priority code, a destination d below NUM_UNITS sets only bit d of `tgt_mask`. Any other destination except 0xFF gives an all-zero mask.
- R3: In logical mode (`msg_logical`=1), bit i of the matched set is 1 exactly when unit i's logical byte (`unit_ldest[8*i+7:8*i]`) ANDed with the destination byte is nonzero.
- R4: Lowest-priority delivery (`msg_dlv`=3'b001) in physical mode is illegal. The result has `tgt_valid`=1, `tgt_err`=1 and `tgt_mask`=0.
- R5: Lowest-priority delivery in logical mode with a non-empty matched set gives a one-hot mask. The set bit is the member of rank (counter mod set size) in the matched set, where rank 0 is the lowest-numbered unit.
- R6: The rotation counter steps by one only after a lowest-priority delivery that had a non-empty matched set. An empty set, an illegal message, another delivery code or an idle cycle leaves it unchanged. It is CNT_W bits wide and wraps.
- R7: `tgt_valid` follows `msg_valid` by exactly one clock. While `tgt_valid` is 0, `tgt_mask` and `tgt_err` are 0.
- R8: While `rst_n` is low, all outputs are 0. After reset the rotation counter starts at 0.
- R9: Delivery codes other than 3'b001 pass the matched set through unchanged, with `tgt_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message strobe, one cycle per message |
| msg_dest | input | 8 | Destination byte |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_dlv | input | 3 | Delivery code, 3'b001 = lowest-priority |
| unit_ldest | input | 8*NUM_UNITS | Logical-destination byte of each unit, unit i at bits 8*i+7:8*i |
| tgt_valid | output | 1 | Result strobe |
| tgt_mask | output | NUM_UNITS | Units that receive the message |
| tgt_err | output | 1 | Illegal physical lowest-priority request |

## Verification
The bench builds the block with its defaults: NUM_UNITS=8 and an 8-bit rotation counter. The full unit count lets the all-units case, the highest legal unit number and the first out-of-range number (8) all appear in one build. The unit logical bytes repeat every four units, so every logical match covers two to eight units. The rotation can then be seen with set sizes 2, 4 and 8, and the counter modulo a shrinking or growing set is checked across back-to-back messages, with empty and illegal messages placed between them.

// File: rtl/irq_dest_pkg.sv
// Package: shared constants and types for the interrupt destination resolver.
// Assumes 8-bit destination bytes and 3-bit delivery codes.
package irq_dest_pkg;
    localparam int DEST_W = 8;
    localparam int DLV_W  = 3;

    typedef logic [DEST_W-1:0] dest_t;
    typedef logic [DLV_W-1:0]  dlv_t;

    localparam dlv_t  DLV_LOWEST = 3'b001;
    localparam dest_t DEST_ALL   = 8'hFF;
endpackage

// File: rtl/irq_dest_match.sv
// Module: irq_dest_match
// Builds the matched-unit set from the destination fields. This is pure
// combinational logic.
// Assumes unit IDs run from 0 to NUM_UNITS-1, and that NUM_UNITS fits in a destination byte.
module irq_dest_match
    import irq_dest_pkg::*;
#(
    parameter int NUM_UNITS = 8
) (
    input  dest_t                       dest,
    input  logic                        logical,
    input  logic [NUM_UNITS*DEST_W-1:0] ldest,
    output logic [NUM_UNITS-1:0]        match
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam dest_t UNIT_ID = dest_t'(u);
        logic phys_hit;
        logic logi_hit;

        // Physical hit: broadcast value, or this unit's own number.
        always_comb phys_hit = (dest == DEST_ALL) || (dest == UNIT_ID);

        // Logical hit: any shared bit between the unit's byte and the destination.
        always_comb logi_hit = |(ldest[u*DEST_W +: DEST_W] & dest);

        // Pick the hit that belongs to the addressing mode.
        always_comb match[u] = logical ? logi_hit : phys_hit;
    end
endmodule

// File: rtl/irq_rot_counter.sv
// Module: irq_rot_counter
// A persistent rotation counter. It steps by one when adv is high and wraps at 2**CNT_W.
// Assumes a synchronous active-low reset clears it.
module irq_rot_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] count
);
    // Hold or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (adv) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/irq_nth_select.sv
// Module: irq_nth_select
// From a set of units, keeps only the member whose rank, in ascending unit
// order, equals count modulo the set size. This is pure combinational logic.
// Assumes CNT_W is at least the width of a population count of NUM_UNITS.
module irq_nth_select #(
    parameter int NUM_UNITS = 8,
    parameter int CNT_W     = 8
) (
    input  logic [NUM_UNITS-1:0] set_in,
    input  logic [CNT_W-1:0]     count,
    output logic [NUM_UNITS-1:0] pick,
    output logic                 nonempty
);
    localparam int PW = $clog2(NUM_UNITS + 1);

    logic [PW-1:0]    pop;
    logic [CNT_W-1:0] rank_want;

    // Population count of the set.
    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            pop = pop + PW'(set_in[i]);
        end
    end

    // Wanted rank = count mod set size. It is 0 for an empty set.
    always_comb begin
        nonempty  = (pop != '0);
        rank_want = nonempty ? (count % CNT_W'(pop)) : '0;
    end

    // Walk the set in ascending order and keep the member at the wanted rank.
    always_comb begin
        logic [PW-1:0] rank;
        rank = '0;
        pick = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (set_in[i]) begin
                if (CNT_W'(rank) == rank_want) begin
                    pick[i] = 1'b1;
                end
                rank = rank + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_dest_resolver.sv
// Module: irq_dest_resolver (top)
// Resolves an interrupt message's destination into a registered mask of
// target units. Lowest-priority delivery keeps one member of the matched set,
// chosen by a rotation counter. The illegal physical lowest-priority case
// raises an error and delivers to no unit.
// Assumes at most one message per cycle. The result appears one cycle after msg_valid.
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int CNT_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        msg_valid,
    input  logic [7:0]                  msg_dest,
    input  logic                        msg_logical,
    input  logic [2:0]                  msg_dlv,
    input  logic [NUM_UNITS*8-1:0]      unit_ldest,
    output logic                        tgt_valid,
    output logic [NUM_UNITS-1:0]        tgt_mask,
    output logic                        tgt_err
);
    logic [NUM_UNITS-1:0] match;
    logic [NUM_UNITS-1:0] pick;
    logic                 nonempty;
    logic [CNT_W-1:0]     rot_count;
    logic                 is_lowest;
    logic                 illegal;
    logic                 rot_adv;
    logic [NUM_UNITS-1:0] next_mask;

    irq_dest_match #(.NUM_UNITS(NUM_UNITS)) u_match (
        .dest    (msg_dest),
        .logical (msg_logical),
        .ldest   (unit_ldest),
        .match   (match)
    );

    irq_nth_select #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W)) u_select (
        .set_in   (match),
        .count    (rot_count),
        .pick     (pick),
        .nonempty (nonempty)
    );

    irq_rot_counter #(.CNT_W(CNT_W)) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rot_adv),
        .count (rot_count)
    );

    // Decode the delivery code and flag the illegal physical lowest-priority case.
    always_comb begin
        is_lowest = (dlv_t'(msg_dlv) == DLV_LOWEST);
        illegal   = is_lowest && !msg_logical;
        rot_adv   = msg_valid && is_lowest && msg_logical && nonempty;
    end

    // Choose the mask to deliver: none, the rotated pick, or the whole set.
    always_comb begin
        if (illegal) begin
            next_mask = '0;
        end else if (is_lowest) begin
            next_mask = pick;
        end else begin
            next_mask = match;
        end
    end

    // Register the result. Outputs stay at zero between messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_valid <= 1'b0;
            tgt_mask  <= '0;
            tgt_err   <= 1'b0;
        end else begin
            tgt_valid <= msg_valid;
            tgt_mask  <= msg_valid ? next_mask : '0;
            tgt_err   <= msg_valid && illegal;
        end
    end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
// Module: irq_dest_resolver_chk
// Port-level temporal checks for irq_dest_resolver. It is attached with bind.
module irq_dest_resolver_chk #(
    parameter int NUM_UNITS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   msg_valid,
    input logic [7:0]             msg_dest,
    input logic                   msg_logical,
    input logic [2:0]             msg_dlv,
    input logic                   tgt_valid,
    input logic [NUM_UNITS-1:0]   tgt_mask,
    input logic                   tgt_err
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> tgt_valid);

    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> !tgt_valid);

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_valid |-> (tgt_mask == '0) && !tgt_err);

    assert_broadcast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_logical && msg_dest == 8'hFF && msg_dlv != 3'b001)
        |=> (&tgt_mask));

    assert_phys_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_logical && msg_dest != 8'hFF && msg_dlv != 3'b001)
        |=> ($countones(tgt_mask) <= 1));

    assert_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_logical && msg_dlv == 3'b001)
        |=> tgt_err && (tgt_mask == '0));

    assert_lowest_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_logical && msg_dlv == 3'b001)
        |=> $onehot0(tgt_mask));

    assert_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !(msg_dlv == 3'b001 && !msg_logical)) |=> !tgt_err);
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_dest    (msg_dest),
    .msg_logical (msg_logical),
    .msg_dlv     (msg_dlv),
    .tgt_valid   (tgt_valid),
    .tgt_mask    (tgt_mask),
    .tgt_err     (tgt_err)
);

// File: tb/irq_dest_resolver_tb.sv
`timescale 1ns/1ps
module irq_dest_resolver_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msg_valid = 1'b0;
    logic [7:0]   msg_dest = '0;
    logic         msg_logical = 1'b0;
    logic [2:0]   msg_dlv = '0;
    logic [N*8-1:0] unit_ldest;
    logic         tgt_valid;
    logic [N-1:0] tgt_mask;
    logic         tgt_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    irq_dest_resolver #(.NUM_UNITS(N), .CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
        .msg_logical(msg_logical), .msg_dlv(msg_dlv), .unit_ldest(unit_ldest),
        .tgt_valid(tgt_valid), .tgt_mask(tgt_mask), .tgt_err(tgt_err)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [7:0] dest;
        logic       logical;
        logic [2:0] dlv;
        logic [7:0] mask;
        logic       err;
    } vec_t;

    // Unit logical bytes: unit i holds 1 << (i % 4).
    // The expected masks assume the rotation counter starts at 0 after reset.
    localparam vec_t VECS [22] = '{
        '{8'h03, 1'b0, 3'b000, 8'h08, 1'b0},  // R2 unit 3
        '{8'hFF, 1'b0, 3'b000, 8'hFF, 1'b0},  // R1 broadcast
        '{8'h07, 1'b0, 3'b000, 8'h80, 1'b0},  // R2 top unit
        '{8'h08, 1'b0, 3'b000, 8'h00, 1'b0},  // R2 out of range
        '{8'hFE, 1'b0, 3'b000, 8'h00, 1'b0},  // R2 out of range
        '{8'h01, 1'b1, 3'b000, 8'h11, 1'b0},  // R3
        '{8'h03, 1'b1, 3'b000, 8'h33, 1'b0},  // R3
        '{8'h10, 1'b1, 3'b000, 8'h00, 1'b0},  // R3 no match
        '{8'h0C, 1'b1, 3'b000, 8'hCC, 1'b0},  // R3
        '{8'h02, 1'b0, 3'b001, 8'h00, 1'b1},  // R4 illegal, counter 0
        '{8'h03, 1'b1, 3'b001, 8'h01, 1'b0},  // R5 c=0 of {0,1,4,5}
        '{8'h03, 1'b1, 3'b001, 8'h02, 1'b0},  // R5 c=1
        '{8'h01, 1'b1, 3'b001, 8'h01, 1'b0},  // R5 c=2 of {0,4}
        '{8'h10, 1'b1, 3'b001, 8'h00, 1'b0},  // R6 empty, counter stays 3
        '{8'h03, 1'b1, 3'b001, 8'h20, 1'b0},  // R6 c=3 -> unit 5
        '{8'h0C, 1'b1, 3'b001, 8'h04, 1'b0},  // R5 c=4 of {2,3,6,7}
        '{8'hFF, 1'b0, 3'b001, 8'h00, 1'b1},  // R4 illegal, counter stays 5
        '{8'hFF, 1'b1, 3'b001, 8'h20, 1'b0},  // R6 c=5 of all
        '{8'h04, 1'b1, 3'b001, 8'h04, 1'b0},  // R5 c=6 of {2,6}
        '{8'h04, 1'b1, 3'b001, 8'h40, 1'b0},  // R5 c=7
        '{8'h02, 1'b1, 3'b100, 8'h22, 1'b0},  // R9 other code, counter stays 8
        '{8'h0F, 1'b1, 3'b001, 8'h01, 1'b0}   // R6 c=8 of all
    };

    task automatic check(string tag, logic ev, logic [7:0] em, logic ee);
        checks++;
        if (tgt_valid !== ev || tgt_mask !== em || tgt_err !== ee) begin
            failures++;
            $display("FAIL %s: got valid=%b mask=%h err=%b, expected valid=%b mask=%h err=%b",
                     tag, tgt_valid, tgt_mask, tgt_err, ev, em, ee);
        end
    endtask

    task automatic send(logic [7:0] d, logic lg, logic [2:0] dl);
        msg_valid = 1'b1; msg_dest = d; msg_logical = lg; msg_dlv = dl;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) unit_ldest[i*8 +: 8] = 8'(1 << (i % 4));
        repeat (3) @(negedge clk);
        check("R8 reset state", 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle after reset", 1'b0, 8'h00, 1'b0);

        // Table walk, one message per cycle back to back.
        for (int i = 0; i < 22; i++) begin
            msg_valid = 1'b1;
            msg_dest = VECS[i].dest;
            msg_logical = VECS[i].logical;
            msg_dlv = VECS[i].dlv;
            @(negedge clk);
            check($sformatf("R1-R9 table[%0d] (R5,R6)", i), 1'b1, VECS[i].mask, VECS[i].err);
        end
        msg_valid = 1'b0;

        // Idle cycles with lowest-priority fields present: no output, no counter step (R6, R7).
        msg_dest = 8'hFF; msg_logical = 1'b1; msg_dlv = 3'b001;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 no output while idle", 1'b0, 8'h00, 1'b0);
        end
        send(8'hFF, 1'b1, 3'b001);  // counter 9 -> rank 1 of all units
        check("R6 counter held over idle", 1'b1, 8'h02, 1'b0);
        @(negedge clk);
        check("R7 valid drops after one cycle", 1'b0, 8'h00, 1'b0);

        // A changed logical byte per unit: all units share bit 7 (R3).
        for (int i = 0; i < N; i++) unit_ldest[i*8 +: 8] = 8'h80;
        send(8'h80, 1'b1, 3'b000);
        check("R3 shared bit matches all", 1'b1, 8'hFF, 1'b0);
        send(8'h7F, 1'b1, 3'b000);
        check("R3 no shared bit", 1'b1, 8'h00, 1'b0);

        // Reset clears the counter (R8).
        msg_valid = 1'b1; msg_dest = 8'h80; msg_logical = 1'b1; msg_dlv = 3'b001;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 outputs held low in reset", 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        check("R8 counter restarts at 0", 1'b1, 8'h01, 1'b0);
        send(8'h80, 1'b1, 3'b001);
        check("R6 step after reset", 1'b1, 8'h02, 1'b0);

        finish_run();
    end
endmodule